// File: doc/BRIEF.md
# Functional Reset Event Router

This block sits between the detectors of ten functional fault or reset events and the parts of the chip that act on them. For every event it decides, one clock after the event is seen, whether to ask the reset sequencer for a reset, to ask the mode controller for a move to SAFE mode, or to raise an interrupt. A per-source disable bit picks between "reset" and "alternate handling". When a source is disabled, a per-source alternate bit picks between SAFE and interrupt. The external reset source is the one exception: when it is disabled it always goes to SAFE.

Software sets the policy through a small word-addressed register bus. Every bus access carries a privilege tag. The disable register is guarded in two ways. Only supervisor or test privilege may write it. Each of its bytes also takes only one write between power-on resets, so once the policy is set it cannot be changed by later code or by a runaway routine. A sticky per-source cause register records every event that arrived. It is cleared by writing ones to it.

The single `rst_n` input is the power-on reset. Reset requests raised by this block do not clear any of its state.

Top module: `rst_evt_router`

## Requirements
- R1: Source bit positions in the event input and in every register: 0 external reset, 1 JTAG reset, 2 debug core reset, 3 software reset, 4 checkstop, 5 PLL fail, 6 oscillator below reference, 7 clock monitor out of range, 8 4.5 V low-voltage detect, 9 flash fatal error. All outputs are registered and respond in the clock cycle after the event is sampled.
- R2: An event whose disable bit is 0 raises `reset_req_o` for one cycle.
- R3: An event whose disable bit is 1 never raises `reset_req_o`. It raises `safe_req_o` if its alternate bit is 0, and `irq_o` if its alternate bit is 1.
- R4: When the external reset source (bit 0) is disabled, its event raises `safe_req_o` and never `irq_o`, whatever alternate bit 0 holds.
- R5: Privilege codes are 2'b01 supervisor and 2'b10 test, which may write; 2'b00 user and 2'b11 reserved, which may not. A write with a non-writing code changes no register. Reads are allowed under every code.
- R6: After power-on reset, each byte of the disable register accepts exactly one permitted write. Byte 0 is bits 7:0 and byte 1 is bits 9:8. Later writes to a locked byte have no effect, and the bytes lock independently.
- R7: The lock flags and disable bits are cleared only by `rst_n`. Reset requests raised by the block leave them unchanged.
- R8: When several events arrive in one cycle, `reset_req_o` is raised if any enabled source fired. `safe_req_o` and `irq_o` are raised for the disabled sources that route to them, in the same cycle.
- R9: Cause bit i is set by any event on source i and stays set. Writing 1 to a bit at address 2 clears it. A set and a clear of the same bit in the same cycle leave it set.
- R10: Register map: address 0 is disable, address 1 is alternate (no write limit), address 2 is cause. Read data appears on `bus_rdata_o` in the cycle after the request. Bytes whose enable is 0 read as zero.
- R11: An access with all byte enables 0, or to any other address, reads as zero and changes nothing. In particular it consumes no write-once lock.
- R12: After power-on reset all outputs are 0 and all three registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| evt_i | input | SRC_N | Per-source functional event, sampled each cycle |
| bus_req_i | input | 1 | Bus access valid |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_be_i | input | DATA_W/8 | Byte enables |
| bus_wdata_i | input | DATA_W | Write data |
| bus_priv_i | input | 2 | Privilege tag of the access |
| bus_rdata_o | output | DATA_W | Registered read data |
| reset_req_o | output | 1 | Reset sequence request |
| safe_req_o | output | 1 | SAFE mode request |
| irq_o | output | 1 | Interrupt request |
| cause_o | output | SRC_N | Sticky per-source cause flags |

## Verification
The assertions check the routing on every cycle. An enabled event always leads to a reset request, and a set of events that are all disabled never does. A disabled external reset is always SAFE and never an interrupt. No event means no request. Writes under a non-writing privilege leave the policy untouched, and a locked byte of the disable register never changes and never unlocks. The bench's scenarios are what show the remaining behaviour, which depends on a sequence of bus accesses: the byte-wise write-once order, the readback of partial and invalid accesses, write-1-to-clear racing a new event, and the routing sweep over every source under four policies.

// File: rtl/rer_pkg.sv
package rer_pkg;

  localparam int unsigned SRC_COUNT = 10;

  // Source positions (R1)
  localparam int unsigned SRC_EXT_RST  = 0;
  localparam int unsigned SRC_JTAG     = 1;
  localparam int unsigned SRC_DBG_CORE = 2;
  localparam int unsigned SRC_SW_RST   = 3;
  localparam int unsigned SRC_CHKSTOP  = 4;
  localparam int unsigned SRC_PLL      = 5;
  localparam int unsigned SRC_OSC_LOW  = 6;
  localparam int unsigned SRC_CLK_MON  = 7;
  localparam int unsigned SRC_LVD      = 8;
  localparam int unsigned SRC_FLASH    = 9;

  // Word addresses (R10)
  localparam int unsigned ADDR_DISABLE = 0;
  localparam int unsigned ADDR_ALT     = 1;
  localparam int unsigned ADDR_CAUSE   = 2;

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUPV = 2'b01,
    PRIV_TEST = 2'b10,
    PRIV_RSVD = 2'b11
  } priv_e;

  // R5: only supervisor and test may modify registers
  function automatic logic priv_may_write(input logic [1:0] p);
    return (p == PRIV_SUPV) || (p == PRIV_TEST);
  endfunction

endpackage

// File: rtl/rer_rst_sync.sv
module rer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_por_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rer_lock_byte.sv
module rer_lock_byte #(
  parameter int unsigned        BYTE_W = 8,
  parameter logic [BYTE_W-1:0]  KEEP   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] val_o,
  output logic              locked_o
);

  logic [BYTE_W-1:0] val_q;
  logic [BYTE_W-1:0] val_d;
  logic              lock_q;
  logic              load;

  // R6: first permitted write loads and locks; later writes are dropped
  always_comb begin
    load  = wr_en && !lock_q;
    val_d = wdata & KEEP;
  end

  // R7: only the power-on reset clears value and lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      lock_q <= 1'b0;
    end else if (load) begin
      val_q  <= val_d;
      lock_q <= 1'b1;
    end
  end

  assign val_o    = val_q;
  assign locked_o = lock_q;

endmodule

// File: rtl/rer_regbank.sv
module rer_regbank
  import rer_pkg::*;
#(
  parameter int unsigned SRC_N  = SRC_COUNT,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBYTE-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        priv_i,
  input  logic [SRC_N-1:0]  cause_set_i,
  output logic [SRC_N-1:0]  dis_o,
  output logic [SRC_N-1:0]  alt_o,
  output logic [SRC_N-1:0]  cause_o,
  output logic [NBYTE-1:0]  lock_o,
  output logic [DATA_W-1:0] rdata_o
);

  function automatic logic [DATA_W-1:0] low_ones(input int unsigned n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SRC_MASK = low_ones(SRC_N);

  logic              be_ok;
  logic              hit_dis;
  logic              hit_alt;
  logic              hit_cause;
  logic              mapped;
  logic              wr_ok;
  logic              rd_ok;
  logic [DATA_W-1:0] be_bits;

  logic [DATA_W-1:0] dis_full;
  logic [DATA_W-1:0] alt_q;
  logic [DATA_W-1:0] alt_d;
  logic              alt_en;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] cause_d;
  logic [DATA_W-1:0] cause_clr;
  logic [DATA_W-1:0] cause_set;
  logic              cause_en;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rd_sel;
  logic              rdata_en;

  // Access decode (R5, R10, R11)
  always_comb begin
    for (int b = 0; b < int'(NBYTE); b++) begin
      be_bits[b*8 +: 8] = {8{be_i[b]}};
    end
    be_ok     = |be_i;
    hit_dis   = (addr_i == ADDR_W'(ADDR_DISABLE));
    hit_alt   = (addr_i == ADDR_W'(ADDR_ALT));
    hit_cause = (addr_i == ADDR_W'(ADDR_CAUSE));
    mapped    = hit_dis || hit_alt || hit_cause;
    wr_ok     = req_i && wr_i && be_ok && mapped && priv_may_write(priv_i);
    rd_ok     = req_i && !wr_i && be_ok && mapped;
  end

  // Write-once disable bytes (R6)
  for (genvar b = 0; b < NBYTE; b++) begin : g_dis_byte
    rer_lock_byte #(
      .BYTE_W (8),
      .KEEP   (SRC_MASK[b*8 +: 8])
    ) u_byte (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok && hit_dis && be_i[b]),
      .wdata    (wdata_i[b*8 +: 8]),
      .val_o    (dis_full[b*8 +: 8]),
      .locked_o (lock_o[b])
    );
  end

  // Alternate-request register, freely rewritable
  always_comb begin
    alt_en = wr_ok && hit_alt;
    alt_d  = ((alt_q & ~be_bits) | (wdata_i & be_bits)) & SRC_MASK;
  end

  // Sticky cause flags, write-1-to-clear, set wins (R9)
  always_comb begin
    cause_set = DATA_W'(cause_set_i);
    cause_clr = (wr_ok && hit_cause) ? (wdata_i & be_bits) : '0;
    cause_d   = ((cause_q & ~cause_clr) | cause_set) & SRC_MASK;
    cause_en  = (|cause_set_i) || (wr_ok && hit_cause);
  end

  // Registered read data (R10, R11)
  always_comb begin
    if (hit_dis) begin
      rd_sel = dis_full;
    end else if (hit_alt) begin
      rd_sel = alt_q;
    end else if (hit_cause) begin
      rd_sel = cause_q;
    end else begin
      rd_sel = '0;
    end
    rdata_d  = rd_ok ? (rd_sel & be_bits) : '0;
    rdata_en = rd_ok || (rdata_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= '0;
    end else if (alt_en) begin
      alt_q <= alt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign dis_o   = dis_full[SRC_N-1:0];
  assign alt_o   = alt_q[SRC_N-1:0];
  assign cause_o = cause_q[SRC_N-1:0];
  assign rdata_o = rdata_q;

endmodule

// File: rtl/rer_route.sv
module rer_route #(
  parameter int unsigned SRC_N   = 10,
  parameter int unsigned EXT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] dis_i,
  input  logic [SRC_N-1:0] alt_i,
  output logic             reset_req_o,
  output logic             safe_req_o,
  output logic             irq_o
);

  // R4: the external reset source can never take the interrupt path
  localparam logic [SRC_N-1:0] IRQ_ABLE = ~(SRC_N'(1) << EXT_IDX);

  logic [SRC_N-1:0] to_alt;
  logic [SRC_N-1:0] to_irq;
  logic [SRC_N-1:0] to_safe;
  logic             rst_d;
  logic             safe_d;
  logic             irq_d;
  logic             out_en;
  logic             rst_q;
  logic             safe_q;
  logic             irq_q;

  // R2, R3, R8: every firing source is routed independently
  always_comb begin
    to_alt  = evt_i & dis_i;
    to_irq  = to_alt & alt_i & IRQ_ABLE;
    to_safe = to_alt & ~to_irq;
    rst_d   = |(evt_i & ~dis_i);
    safe_d  = |to_safe;
    irq_d   = |to_irq;
    out_en  = (|evt_i) || rst_q || safe_q || irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      safe_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (out_en) begin
      rst_q  <= rst_d;
      safe_q <= safe_d;
      irq_q  <= irq_d;
    end
  end

  assign reset_req_o = rst_q;
  assign safe_req_o  = safe_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/rst_evt_router.sv
module rst_evt_router
  import rer_pkg::*;
#(
  parameter int unsigned SRC_N      = SRC_COUNT,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned SYNC_STAGE = 2,
  localparam int unsigned NBYTE     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              bus_req_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NBYTE-1:0]  bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [1:0]        bus_priv_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              reset_req_o,
  output logic              safe_req_o,
  output logic              irq_o,
  output logic [SRC_N-1:0]  cause_o
);

  logic             rst_s_n;
  logic [SRC_N-1:0] dis_w;
  logic [SRC_N-1:0] alt_w;
  logic [NBYTE-1:0] lock_w;

  rer_rst_sync #(
    .STAGES (SYNC_STAGE)
  ) u_rst_sync (
    .clk        (clk),
    .rst_por_n  (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rer_regbank #(
    .SRC_N  (SRC_N),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regbank (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .req_i       (bus_req_i),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .be_i        (bus_be_i),
    .wdata_i     (bus_wdata_i),
    .priv_i      (bus_priv_i),
    .cause_set_i (evt_i),
    .dis_o       (dis_w),
    .alt_o       (alt_w),
    .cause_o     (cause_o),
    .lock_o      (lock_w),
    .rdata_o     (bus_rdata_o)
  );

  rer_route #(
    .SRC_N   (SRC_N),
    .EXT_IDX (SRC_EXT_RST)
  ) u_route (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .evt_i       (evt_i),
    .dis_i       (dis_w),
    .alt_i       (alt_w),
    .reset_req_o (reset_req_o),
    .safe_req_o  (safe_req_o),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/rst_evt_router_chk.sv
module rst_evt_router_chk
  import rer_pkg::*;
#(
  parameter int unsigned SRC_N = 10,
  parameter int unsigned NBYTE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] evt_i,
  input logic [SRC_N-1:0] dis,
  input logic [SRC_N-1:0] alt,
  input logic [NBYTE-1:0] lock,
  input logic             bus_req_i,
  input logic             bus_wr_i,
  input logic [1:0]       bus_priv_i,
  input logic             reset_req_o,
  input logic             safe_req_o,
  input logic             irq_o
);

  function automatic logic [SRC_N-1:0] byte_mask(input int unsigned b);
    logic [SRC_N-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < SRC_N; i++) begin
      if ((i / 8) == b) m[i] = 1'b1;
    end
    return m;
  endfunction

  assert_enabled_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~dis)) |=> reset_req_o);

  assert_disabled_no_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i != '0) && ((evt_i & ~dis) == '0)) |=> !reset_req_o);

  assert_ext_goes_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[SRC_EXT_RST] && dis[SRC_EXT_RST]) |=> safe_req_o);

  assert_ext_never_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == SRC_N'(1) << SRC_EXT_RST) && dis[SRC_EXT_RST]) |=> !irq_o);

  assert_user_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && bus_wr_i && !priv_may_write(bus_priv_i)) |=> ($stable(dis) && $stable(alt)));

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0) |=> (!reset_req_o && !safe_req_o && !irq_o));

  for (genvar b = 0; b < NBYTE; b++) begin : g_lock
    localparam logic [SRC_N-1:0] BM = byte_mask(b);

    assert_locked_byte_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock[b] |=> $stable(dis & BM));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock[b] |=> lock[b]);
  end

endmodule

bind rst_evt_router rst_evt_router_chk #(
  .SRC_N (SRC_N),
  .NBYTE (NBYTE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_s_n),
  .evt_i       (evt_i),
  .dis         (dis_w),
  .alt         (alt_w),
  .lock        (lock_w),
  .bus_req_i   (bus_req_i),
  .bus_wr_i    (bus_wr_i),
  .bus_priv_i  (bus_priv_i),
  .reset_req_o (reset_req_o),
  .safe_req_o  (safe_req_o),
  .irq_o       (irq_o)
);

// File: tb/tb_rst_evt_router.sv
module tb_rst_evt_router;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [9:0]  evt;
  logic        req;
  logic        wr;
  logic [3:0]  addr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [1:0]  priv;
  logic [15:0] rdata;
  logic        reset_req;
  logic        safe_req;
  logic        irq;
  logic [9:0]  cause;

  int n_run;
  int n_fail;
  bit done;
  logic [9:0] exp_cause;

  rst_evt_router dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .bus_req_i   (req),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_be_i    (be),
    .bus_wdata_i (wdata),
    .bus_priv_i  (priv),
    .bus_rdata_o (rdata),
    .reset_req_o (reset_req),
    .safe_req_o  (safe_req),
    .irq_o       (irq),
    .cause_o     (cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic por;
    rst_n = 1'b0; evt = '0; req = 1'b0; wr = 1'b0; addr = '0;
    be = '0; wdata = '0; priv = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    exp_cause = '0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [1:0] b,
                        input logic [15:0] d, input logic [1:0] p);
    req = 1'b1; wr = 1'b1; addr = a; be = b; wdata = d; priv = p;
    tick();
    req = 1'b0; wr = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [1:0] b,
                        input logic [1:0] p, output logic [15:0] d);
    req = 1'b1; wr = 1'b0; addr = a; be = b; priv = p;
    tick();
    d = rdata;
    req = 1'b0; be = '0;
  endtask

  // Expected routing computed from R2, R3, R4, R8
  task automatic fire(input logic [9:0] e, input logic [9:0] d, input logic [9:0] a);
    logic er, es, ei;
    er = |(e & ~d);
    ei = |(e & d & a & 10'h3FE);
    es = |(e & d & ~(a & 10'h3FE));
    evt = e;
    tick();
    evt = '0;
    exp_cause = exp_cause | e;
    chk("R2/R8 reset_req", {31'd0, reset_req}, {31'd0, er});
    chk("R3/R4 safe_req", {31'd0, safe_req}, {31'd0, es});
    chk("R3/R4 irq", {31'd0, irq}, {31'd0, ei});
    chk("R9 cause sticky", {22'd0, cause}, {22'd0, exp_cause});
  endtask

  logic [9:0] cfg_dis [4];
  logic [9:0] cfg_alt [4];

  initial begin
    logic [15:0] rv;
    logic [9:0]  lf;
    n_run = 0; n_fail = 0; done = 1'b0;
    cfg_dis[0] = 10'h000; cfg_alt[0] = 10'h3FF;
    cfg_dis[1] = 10'h3FF; cfg_alt[1] = 10'h3FF;
    cfg_dis[2] = 10'h3FF; cfg_alt[2] = 10'h000;
    cfg_dis[3] = 10'h2B5; cfg_alt[3] = 10'h1CB;

    for (int k = 0; k < 4; k++) begin
      logic [9:0] d;
      logic [9:0] a;
      d = cfg_dis[k];
      a = cfg_alt[k];
      por();

      if (k == 0) begin
        chk("R12 reset_req", {31'd0, reset_req}, 32'd0);
        chk("R12 safe_req", {31'd0, safe_req}, 32'd0);
        chk("R12 irq", {31'd0, irq}, 32'd0);
        chk("R12 cause", {22'd0, cause}, 32'd0);
        chk("R12 rdata", {16'd0, rdata}, 32'd0);
        bus_rd(4'd0, 2'b11, 2'b01, rv); chk("R12 disable reads 0", {16'd0, rv}, 32'd0);
        bus_rd(4'd1, 2'b11, 2'b01, rv); chk("R12 alt reads 0", {16'd0, rv}, 32'd0);
        bus_rd(4'd2, 2'b11, 2'b01, rv); chk("R12 cause reads 0", {16'd0, rv}, 32'd0);
      end

      // R5: user and reserved codes cannot write
      bus_wr(4'd0, 2'b11, 16'h03FF, 2'b00);
      bus_wr(4'd1, 2'b11, 16'h03FF, 2'b00);
      bus_wr(4'd0, 2'b11, 16'h03FF, 2'b11);
      bus_rd(4'd0, 2'b11, 2'b00, rv); chk("R5 user write to disable ignored", {16'd0, rv}, 32'd0);
      bus_rd(4'd1, 2'b11, 2'b11, rv); chk("R5 user write to alt ignored", {16'd0, rv}, 32'd0);

      // R11: no byte enable / unmapped address change nothing and lock nothing
      bus_wr(4'd0, 2'b00, 16'h03FF, 2'b01);
      bus_wr(4'd7, 2'b11, 16'h03FF, 2'b10);
      bus_rd(4'd0, 2'b00, 2'b01, rv); chk("R11 read with no byte enable", {16'd0, rv}, 32'd0);
      bus_rd(4'd7, 2'b11, 2'b01, rv); chk("R11 unmapped read", {16'd0, rv}, 32'd0);
      bus_rd(4'd0, 2'b11, 2'b01, rv); chk("R11 disable untouched", {16'd0, rv}, 32'd0);

      // Alternate register: rewritable (R10)
      bus_wr(4'd1, 2'b11, {6'd0, ~a}, 2'b01);
      bus_wr(4'd1, 2'b11, {6'd0, a}, 2'b10);
      bus_rd(4'd1, 2'b11, 2'b00, rv); chk("R10 alt readback", {16'd0, rv}, {22'd0, a});

      // R6: byte-wise write-once
      bus_wr(4'd0, 2'b01, {6'd0, d}, 2'b01);
      bus_wr(4'd0, 2'b01, {6'd0, ~d}, 2'b01);
      bus_rd(4'd0, 2'b01, 2'b00, rv); chk("R6 byte0 locked after first write", {16'd0, rv}, {24'd0, d[7:0]});
      bus_wr(4'd0, 2'b10, {6'd0, d}, 2'b10);
      bus_wr(4'd0, 2'b11, {6'd0, ~d}, 2'b01);
      bus_rd(4'd0, 2'b11, 2'b00, rv); chk("R6 both bytes locked", {16'd0, rv}, {22'd0, d});
      bus_rd(4'd0, 2'b10, 2'b00, rv); chk("R10 upper byte only read", {16'd0, rv}, {22'd0, d[9:8], 8'd0});

      bus_wr(4'd2, 2'b11, 16'hFFFF, 2'b01);
      exp_cause = '0;

      // R1: every source alone
      for (int i = 0; i < 10; i++) begin
        fire(10'(1) << i, d, a);
      end
      tick();
      chk("R1 outputs drop without events", {29'd0, reset_req, safe_req, irq}, 32'd0);

      // R8: mixed patterns
      lf = 10'h1A5 ^ 10'(k * 37);
      for (int j = 0; j < 40; j++) begin
        lf = {lf[8:0], lf[9] ^ lf[6]};
        if (lf == '0) lf = 10'h001;
        fire(lf, d, a);
      end

      // R9: readback, partial W1C, user clear ignored, set beats clear
      bus_rd(4'd2, 2'b11, 2'b00, rv); chk("R9 cause readback", {16'd0, rv}, {22'd0, exp_cause});
      bus_wr(4'd2, 2'b11, 16'hFFFF, 2'b00);
      chk("R5 user clear ignored", {22'd0, cause}, {22'd0, exp_cause});
      bus_wr(4'd2, 2'b01, 16'hFFFF, 2'b01);
      exp_cause = exp_cause & 10'h300;
      chk("R9 byte0 cleared", {22'd0, cause}, {22'd0, exp_cause});
      evt = 10'h008; req = 1'b1; wr = 1'b1; addr = 4'd2; be = 2'b11; wdata = 16'hFFFF; priv = 2'b10;
      tick();
      evt = '0; req = 1'b0; wr = 1'b0; be = '0;
      chk("R9 set wins over clear", {22'd0, cause}, 32'h008);

      // R7: reset requests do not reopen the disable register
      bus_wr(4'd0, 2'b11, {6'd0, ~d}, 2'b10);
      bus_rd(4'd0, 2'b11, 2'b01, rv); chk("R7 disable kept after reset requests", {16'd0, rv}, {22'd0, d});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule